// File: doc/BRIEF.md
# All-ones Alarm Detector

This block watches a received serial bit stream and raises an alarm flag when the stream carries almost nothing but ones, which is how an upstream failure is signalled on a line. Bits arrive one per clock cycle in which the valid strobe is high. The decision depends on how many zeros occur per window, and three window rules can be selected. The first is a sliding window of the most recent 8192 bits, where the alarm holds while fewer than 9 zeros are in the window. The second needs two adjacent 512-bit blocks that agree. The third decides on each 512-bit block alone.

The sliding rule does not keep a copy of the 8192-bit history. It stores only the 13-bit arrival indexes of the latest nine zeros in a small circular buffer. A zero drops out of the window when a new bit arrives with the same index modulo 8192. Changing the rule, or dropping the detection enable, restarts every counter and clears the flag. A one-cycle pulse marks every change of the flag.

Top module: `ais_monitor`

## Requirements
- R1: After reset, and after any restart, `ais` is 0 and `ais_chg` is 0. No decision is made before one full window has been received: 8192 bits for the sliding rule, 512 bits for the single-block rule and two blocks for the paired rule.
- R2: Sliding rule: once 8192 bits have been seen, `ais` is set on any bit after which the last 8192 bits hold fewer than 9 zeros. This includes the bit that pushes the ninth-newest zero out of the window.
- R3: Sliding rule: `ais` is cleared on any bit after which the last 8192 bits hold 9 or more zeros. Eight zeros are not enough.
- R4: Paired-block rule: `ais` is set at the last bit of a block when both that block and the previous block each held fewer than 3 zeros. A single low block sets nothing.
- R5: Paired-block rule: `ais` is cleared when both adjacent blocks held 3 or more zeros. A mixed pair leaves `ais` unchanged.
- R6: Single-block rule: at the last bit of each 512-bit block, `ais` is set if the block held fewer than 3 zeros and is cleared otherwise.
- R7: `mode_sel` encoding: 2'b00 selects the sliding rule, 2'b01 the paired-block rule and 2'b10 the single-block rule. 2'b11 acts exactly as 2'b00.
- R8: While `host_en` is 0, `ais` is held at 0 one cycle later and all detection state is cleared. Bits offered during that time have no effect.
- R9: A change of the effective rule clears `ais` at the next clock edge and restarts all counters. Block boundaries realign to the first bit after the change.
- R10: `ais_chg` is high for exactly the cycle after each edge at which `ais` changes value, and at no other time.
- R11: Only cycles with `bit_valid` high count as bits. The value of `bit_data` in other cycles is ignored.
- R12: `ais` takes its new value at the clock edge that samples the deciding bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | High in each cycle that carries a received bit |
| bit_data | input | 1 | Received bit value |
| mode_sel | input | 2 | Window rule select (00 sliding, 01 paired, 10 single, 11 as 00) |
| host_en | input | 1 | Detection enable; when low the flag is forced to 0 |
| ais | output | 1 | Alarm flag, registered |
| ais_chg | output | 1 | One-cycle pulse after each flag change |

## Verification
The embedded assertions check four things on every cycle. The stored zero count never exceeds 9 and the block zero count never exceeds 3. The flag is low one cycle after the enable drops or the rule changes. Every change pulse matches a real flag toggle. What only the bench scenarios can show is the exact bit at which the flag changes: the 8-to-9 zero boundary inside the sliding window, including the bit that ages a zero out; the 2-to-3 boundary per block; the hold on mixed block pairs; and the folding of the reserved code onto the sliding rule.

// File: rtl/ais_pkg.sv
package ais_pkg;

  typedef enum logic [1:0] {
    MODE_SLIDE  = 2'b00,
    MODE_PAIR   = 2'b01,
    MODE_SINGLE = 2'b10,
    MODE_RSVD   = 2'b11
  } ais_mode_e;

  // The reserved code behaves like the sliding rule.
  function automatic ais_mode_e fold_mode(input logic [1:0] sel);
    ais_mode_e m;
    m = ais_mode_e'(sel);
    if (m == MODE_RSVD) m = MODE_SLIDE;
    return m;
  endfunction

endpackage

// File: rtl/ais_slide_win.sv
module ais_slide_win #(
  parameter int WIN_BITS  = 8192,
  parameter int MIN_ZEROS = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic bit_ok,
  input  logic bit_zero,
  output logic set_o,
  output logic clr_o
);
  localparam int TS_W  = $clog2(WIN_BITS);
  localparam int PTR_W = (MIN_ZEROS > 1) ? $clog2(MIN_ZEROS) : 1;
  localparam int CNT_W = $clog2(MIN_ZEROS + 1);
  localparam logic [TS_W-1:0]  TS_LAST  = TS_W'(WIN_BITS - 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(MIN_ZEROS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(MIN_ZEROS);

  // Arrival indexes of the most recent zeros (small memory, no reset)
  logic [TS_W-1:0]  ring [MIN_ZEROS];
  logic [TS_W-1:0]  ts_q, seen_q;
  logic [PTR_W-1:0] old_q, wr_q, old_n, wr_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             leave, enter, we, full_seen, decide;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
  endfunction

  assign full_seen = (seen_q == TS_LAST);
  assign leave     = bit_ok && (cnt_q != '0) && (ring[old_q] == ts_q);
  assign enter     = bit_ok && bit_zero;

  always_comb begin
    cnt_n = cnt_q;
    old_n = old_q;
    wr_n  = wr_q;
    we    = 1'b0;
    if (leave) begin
      old_n = ptr_inc(old_q);
      cnt_n = cnt_q - CNT_W'(1);
    end
    if (enter) begin
      we   = 1'b1;
      wr_n = ptr_inc(wr_q);
      if (!leave && cnt_q == CNT_FULL) old_n = ptr_inc(old_q);
      else                             cnt_n = cnt_n + CNT_W'(1);
    end
  end

  assign decide = bit_ok && full_seen;
  assign set_o  = decide && (cnt_n <  CNT_FULL);
  assign clr_o  = decide && (cnt_n == CNT_FULL);

  always_ff @(posedge clk) begin
    if (we) ring[wr_q] <= ts_q;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      ts_q   <= '0;
      seen_q <= '0;
      old_q  <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
    end else if (bit_ok) begin
      ts_q   <= (ts_q == TS_LAST) ? '0 : ts_q + TS_W'(1);
      if (!full_seen) seen_q <= seen_q + TS_W'(1);
      old_q  <= old_n;
      wr_q   <= wr_n;
      cnt_q  <= cnt_n;
    end
  end

  // R3
  zero_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_FULL);

  // R2
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (old_q <= PTR_LAST) && (wr_q <= PTR_LAST));

endmodule

// File: rtl/ais_block_win.sv
module ais_block_win #(
  parameter int BLK_BITS  = 512,
  parameter int MIN_ZEROS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic bit_ok,
  input  logic bit_zero,
  input  logic pair_rule,
  output logic set_o,
  output logic clr_o
);
  localparam int POS_W = $clog2(BLK_BITS);
  localparam int ZC_W  = $clog2(MIN_ZEROS + 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(BLK_BITS - 1);
  localparam logic [ZC_W-1:0]  ZC_SAT   = ZC_W'(MIN_ZEROS);

  logic [POS_W-1:0] pos_q;
  logic [ZC_W-1:0]  zc_q, zc_n;
  logic             prev_low_q, prev_ok_q;
  logic             last, low, pair_set, pair_clr;

  assign zc_n = (bit_zero && zc_q != ZC_SAT) ? zc_q + ZC_W'(1) : zc_q;
  assign last = bit_ok && (pos_q == POS_LAST);
  assign low  = (zc_n < ZC_SAT);

  assign pair_set = prev_ok_q &&  prev_low_q &&  low;
  assign pair_clr = prev_ok_q && !prev_low_q && !low;

  assign set_o = last && (pair_rule ? pair_set :  low);
  assign clr_o = last && (pair_rule ? pair_clr : !low);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pos_q      <= '0;
      zc_q       <= '0;
      prev_low_q <= 1'b0;
      prev_ok_q  <= 1'b0;
    end else if (bit_ok) begin
      if (last) begin
        pos_q      <= '0;
        zc_q       <= '0;
        prev_low_q <= low;
        prev_ok_q  <= 1'b1;
      end else begin
        pos_q <= pos_q + POS_W'(1);
        zc_q  <= zc_n;
      end
    end
  end

  // R6
  blk_zero_sat_chk: assert property (@(posedge clk) disable iff (rst)
    zc_q <= ZC_SAT);

endmodule

// File: rtl/ais_flag_reg.sv
module ais_flag_reg (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic set_i,
  input  logic clr_i,
  output logic ais_o,
  output logic chg_o
);
  logic ais_n;

  always_comb begin
    ais_n = ais_o;
    if (restart)    ais_n = 1'b0;
    else if (set_i) ais_n = 1'b1;
    else if (clr_i) ais_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ais_o <= 1'b0;
      chg_o <= 1'b0;
    end else begin
      ais_o <= ais_n;
      chg_o <= (ais_n != ais_o);
    end
  end

  // R10
  chg_matches_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    chg_o |-> (ais_o != $past(ais_o)));

  // R1
  set_clr_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(set_i && clr_i));

endmodule

// File: rtl/ais_monitor.sv
module ais_monitor
  import ais_pkg::*;
#(
  parameter int SLIDE_BITS  = 8192,
  parameter int SLIDE_ZEROS = 9,
  parameter int BLOCK_BITS  = 512,
  parameter int BLOCK_ZEROS = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_valid,
  input  logic       bit_data,
  input  logic [1:0] mode_sel,
  input  logic       host_en,
  output logic       ais,
  output logic       ais_chg
);
  ais_mode_e mode_eff, mode_q;
  logic      restart, bit_ok;
  logic      s_set, s_clr, b_set, b_clr, f_set, f_clr;
  logic      is_slide;

  assign mode_eff = fold_mode(mode_sel);
  assign restart  = !host_en || (mode_eff != mode_q);
  assign bit_ok   = bit_valid && !restart;
  assign is_slide = (mode_q == MODE_SLIDE);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_SLIDE;
    else     mode_q <= mode_eff;
  end

  ais_slide_win #(
    .WIN_BITS (SLIDE_BITS),
    .MIN_ZEROS(SLIDE_ZEROS)
  ) u_slide (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .bit_ok  (bit_ok && is_slide),
    .bit_zero(!bit_data),
    .set_o   (s_set),
    .clr_o   (s_clr)
  );

  ais_block_win #(
    .BLK_BITS (BLOCK_BITS),
    .MIN_ZEROS(BLOCK_ZEROS)
  ) u_block (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .bit_ok   (bit_ok && !is_slide),
    .bit_zero (!bit_data),
    .pair_rule(mode_q == MODE_PAIR),
    .set_o    (b_set),
    .clr_o    (b_clr)
  );

  assign f_set = is_slide ? s_set : b_set;
  assign f_clr = is_slide ? s_clr : b_clr;

  ais_flag_reg u_flag (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .set_i  (f_set),
    .clr_i  (f_clr),
    .ais_o  (ais),
    .chg_o  (ais_chg)
  );

  // R8
  host_off_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !host_en |=> !ais);

  // R9
  mode_change_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_eff != mode_q) |=> !ais);

endmodule

// File: tb/sim_ais_monitor.sv
`timescale 1ns/1ps
module sim_ais_monitor;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_valid = 1'b0;
  logic       bit_data = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       host_en = 1'b1;
  logic       ais, ais_chg;

  int checks = 0;
  int failures = 0;
  int nbits = 0;
  int p1 = 0;
  logic prev_ais = 1'b0;

  typedef struct packed {
    logic        val;
    logic [31:0] at;
  } ev_t;
  ev_t evq[$];

  always #2.5 clk = ~clk;

  ais_monitor u0 (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_data(bit_data),
    .mode_sel(mode_sel), .host_en(host_en), .ais(ais), .ais_chg(ais_chg)
  );

  task automatic expect_ev(input logic v, input int at);
    ev_t e;
    e.val = v;
    e.at  = 32'(at);
    evq.push_back(e);
  endtask

  // One bit per two cycles; the idle cycle carries a zero that must be ignored (R11)
  task automatic send(input logic b);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_data  = b;
    @(posedge clk);
    nbits++;
    @(negedge clk);
    bit_valid = 1'b0;
    bit_data  = 1'b0;
  endtask

  task automatic send_n(input int n, input logic b);
    for (int i = 0; i < n; i++) send(b);
  endtask

  task automatic block(input int nz);
    send_n(nz, 1'b0);
    send_n(512 - nz, 1'b1);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode_sel = m;
    @(negedge clk);
  endtask

  task automatic set_host(input logic h);
    @(negedge clk);
    host_en = h;
    @(negedge clk);
  endtask

  task automatic check_ais(input logic exp, input string req);
    checks++;
    if (ais !== exp) begin
      failures++;
      $display("FAIL %s ais actual=%b expected=%b at bit %0d", req, ais, exp, nbits);
    end
  endtask

  // Monitor: pops an expected change for each pulse and compares
  always @(negedge clk) begin
    if (!rst) begin
      if (ais_chg) begin
        checks++;
        if (evq.size() == 0) begin
          failures++;
          $display("FAIL R10 unexpected change actual=%b expected=none at bit %0d", ais, nbits);
        end else begin
          ev_t e;
          e = evq.pop_front();
          if (ais !== e.val || 32'(nbits) != e.at) begin
            failures++;
            $display("FAIL R12 change actual=%b@%0d expected=%b@%0d", ais, nbits, e.val, e.at);
          end
        end
      end else if (ais !== prev_ais) begin
        checks++;
        failures++;
        $display("FAIL R10 toggle without pulse actual=0 expected=1");
      end
      prev_ais = ais;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (ais !== 1'b0 || ais_chg !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset actual=%b%b expected=00", ais, ais_chg);
    end

    // Sliding rule (mode 00)
    send_n(8191, 1'b1);
    check_ais(1'b0, "R1");
    expect_ev(1'b1, nbits + 1);
    send(1'b1);
    check_ais(1'b1, "R2");
    send_n(8, 1'b0);
    p1 = nbits - 7;
    send_n(100, 1'b1);
    check_ais(1'b1, "R3");            // 8 zeros not enough
    expect_ev(1'b0, nbits + 1);
    send(1'b0);                       // ninth zero clears
    check_ais(1'b0, "R3");
    send_n(p1 + 8191 - nbits, 1'b1);
    check_ais(1'b0, "R2");
    expect_ev(1'b1, nbits + 1);
    send(1'b1);                       // first zero ages out
    check_ais(1'b1, "R2");

    // Paired-block rule (mode 01)
    expect_ev(1'b0, nbits);
    set_mode(2'b01);
    check_ais(1'b0, "R9");
    block(2);
    check_ais(1'b0, "R4");            // single low block sets nothing
    expect_ev(1'b1, nbits + 512);
    block(2);
    check_ais(1'b1, "R4");
    block(3);
    check_ais(1'b1, "R5");            // mixed pair holds
    block(2);
    check_ais(1'b1, "R5");
    block(3);
    check_ais(1'b1, "R5");
    expect_ev(1'b0, nbits + 512);
    block(3);
    check_ais(1'b0, "R5");

    // Single-block rule (mode 10)
    set_mode(2'b10);
    expect_ev(1'b1, nbits + 512);
    block(2);
    check_ais(1'b1, "R6");
    expect_ev(1'b0, nbits + 512);
    block(3);
    check_ais(1'b0, "R6");
    expect_ev(1'b1, nbits + 512);
    block(0);
    check_ais(1'b1, "R6");

    // Enable removal
    expect_ev(1'b0, nbits);
    set_host(1'b0);
    check_ais(1'b0, "R8");
    send_n(1024, 1'b1);
    check_ais(1'b0, "R8");
    set_host(1'b1);
    expect_ev(1'b1, nbits + 512);
    block(0);
    check_ais(1'b1, "R8");
    expect_ev(1'b0, nbits + 512);
    block(3);
    check_ais(1'b0, "R6");

    // Reserved code acts as sliding rule: 9 zeros at window end, no alarm
    set_mode(2'b11);
    send_n(8183, 1'b1);
    send_n(9, 1'b0);
    check_ais(1'b0, "R7");

    repeat (4) @(negedge clk);
    checks++;
    if (evq.size() != 0) begin
      failures++;
      $display("FAIL R12 pending events actual=%0d expected=0", evq.size());
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule